// File: doc/BRIEF.md
# MDIO Management Master

This block lets software on a register port manage an Ethernet PHY over the two-wire MDIO management bus. It produces the management clock (MDC) by dividing the system clock and builds clause-22 frames: an optional 32-bit run of ones, the start pattern, the operation code, the PHY and register addresses, a turnaround, and 16 data bits sent most significant bit first. Software writes the addresses and the outgoing data into registers and starts a read or a write through the command register. It then polls the busy flag, collects the returned data, and writes zero to the command register.

A scan command makes the master read one PHY register again and again without software help. Each scan result lands in the receive data register. The link-fail flag follows the inverse of bit 2 of every result. A not-yet-valid flag stays high until the first scan result has arrived. The serial line is split into an output value, an output enable and an input, so the tristate pad stays outside the block.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, the status register (select 5) and the receive data register (select 4) read 0. The mode register (select 0) reads the reset divider value 100 with preamble suppression off. `mdio_oe` is low.
- R2: The divider field is mode bits 7:0, and bit 0 is ignored. One MDC period lasts 2*floor(div/2) system clocks, with a minimum of 2 clocks (div 0 or 1 gives 2).
- R3: Each frame begins with 32 driven ones, unless mode bit 8 is set, in which case the ones are left out. A write frame drives the line for 64 MDC cycles with the preamble and 32 without it. A read frame drives it for 46 cycles with the preamble and 14 without it.
- R4: A write frame sends start 01, opcode 01, the PHY address from address bits 4:0, the register address from address bits 12:8, turnaround 10, and then transmit-data bits 15:0 MSB first. The master changes `mdio_out` and `mdio_oe` only on a falling MDC edge.
- R5: A read frame sends opcode 10 and releases the line (`mdio_oe` low) from the first turnaround bit onward. It samples 16 data bits on rising MDC edges, MSB first, into receive data bits 15:0. If no PHY answers, the line is pulled up and the read returns 0xFFFF.
- R6: The command register (select 1) has three bits: bit 0 scan, bit 1 read, bit 2 write. Writing it with bit 1 or bit 2 set makes status bit 1 (busy) read 1 on the next clock. Busy clears once the frame has ended, and it stays set while the scan bit is 1.
- R7: While command bit 0 is set, reads of the addressed register repeat one after another. Each result updates receive data, and status bit 0 (link fail) is set to the inverse of bit 2 of that result.
- R8: Setting the scan bit sets status bit 2 (invalid). Invalid clears on the falling MDC edge that completes the first scan frame.
- R9: Read-back at the register port: the address register (select 2) keeps only bits 4:0 and 12:8, transmit data (select 3) keeps bits 15:0, mode keeps bits 8:0, and command keeps bits 2:0. All other bits read 0.
- R10: Writing 0 to the command register while the master is idle starts no frame and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 mode, 1 command, 2 address, 3 transmit data, 4 receive data, 5 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Value driven onto the MDIO line |
| mdio_oe | output | 1 | Output enable for the MDIO line |
| mdio_in | input | 1 | MDIO line as seen at the pad |

## Verification
The bench runs a bus-level PHY model that decodes every frame and compares it against a queue of expected frames. Writes and reads are tried with and without the preamble and with divider values 8, 5 and 1. Counting the MDC cycles in which the line is driven separates a missing or extra preamble from an early or late turnaround release. The odd divider shows whether bit 0 is really ignored. A read addressed to an absent PHY must return the pull-up value, which proves the master samples the line only after releasing it. A scan run in which the PHY's status bit 2 flips partway through shows whether link fail follows each new result, and whether invalid drops only after the first completed scan.

// File: rtl/mdio_pkg.sv
// Shared definitions for the MDIO management master: register selects,
// operation kinds and frame geometry constants.
package mdio_pkg;
    localparam int REG_W      = 32;
    localparam int DIV_W      = 8;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int HDR_BITS   = 14;
    localparam int DATA_BITS  = 16;
    localparam int POS_W      = $clog2(PRE_BITS + FRAME_BITS);

    typedef enum logic [2:0] {
        SEL_MODE = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_ADDR = 3'd2,
        SEL_TXD  = 3'd3,
        SEL_RXD  = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SCAN  = 2'd3
    } op_e;
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator.
// Divides the system clock by an even divisor taken from the divider
// field (bit 0 ignored, minimum 2) and flags, one cycle ahead, each MDC
// rising and falling edge so the frame engine can act on the same clock.
// Assumes the divider may change at any time; the compare is ">=" so a
// smaller new value never strands the counter.
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] divider,
    output logic          mdc,
    output logic          rise_stb,
    output logic          fall_stb
);
    localparam int HW = DW - 1;

    logic [HW-1:0] half;
    logic [HW-1:0] half_m1;
    logic [HW-1:0] cnt;
    logic          term;

    // Half period in system clocks; bit 0 of the divider is dropped.
    always_comb begin
        half    = (divider[DW-1:1] == '0) ? HW'(1) : divider[DW-1:1];
        half_m1 = half - HW'(1);
        term    = (cnt >= half_m1);
    end

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HW'(1);
        end
    end

    assign rise_stb = term & ~mdc;
    assign fall_stb = term &  mdc;
endmodule

// File: rtl/mdio_regs.sv
// Register file of the MDIO master.
// Holds mode, command, address and transmit data; latches a pending
// read/write request until the engine takes it; arms the scan-invalid
// flag; combines busy; and serves combinational read-back.
// Assumes a single-cycle write strobe and that software clears the
// command register after each read or write.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int              DW        = DIV_W,
    parameter logic [DW-1:0]   RESET_DIV = DW'(100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             take_rw,
    input  logic             active,
    input  logic [15:0]      rx_data,
    input  logic             link_fail,
    input  logic             invalid,
    output logic [DW-1:0]    divider,
    output logic             no_pre,
    output logic             scan_en,
    output logic             pend_rw,
    output logic             pend_wr,
    output logic             scan_arm,
    output logic [4:0]       phy_ad,
    output logic [4:0]       reg_ad,
    output logic [15:0]      tx_data,
    output logic             busy
);
    logic [2:0] cmd_q;
    logic       wr_cmd;

    assign wr_cmd   = reg_wr && (reg_sel == SEL_CMD);
    assign scan_arm = wr_cmd && reg_wdata[0];
    assign scan_en  = cmd_q[0];
    assign busy     = active | pend_rw | cmd_q[0];

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divider <= RESET_DIV;
            no_pre  <= 1'b0;
            cmd_q   <= '0;
            phy_ad  <= '0;
            reg_ad  <= '0;
            tx_data <= '0;
        end else if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_MODE: begin
                    divider <= reg_wdata[DW-1:0];
                    no_pre  <= reg_wdata[8];
                end
                SEL_CMD:  cmd_q <= reg_wdata[2:0];
                SEL_ADDR: begin
                    phy_ad <= reg_wdata[4:0];
                    reg_ad <= reg_wdata[12:8];
                end
                SEL_TXD:  tx_data <= reg_wdata[15:0];
                default:  ;
            endcase
        end
    end

    // Pending one-shot read/write request, held until the engine starts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_rw <= 1'b0;
            pend_wr <= 1'b0;
        end else if (wr_cmd && (reg_wdata[1] || reg_wdata[2])) begin
            pend_rw <= 1'b1;
            pend_wr <= reg_wdata[2];
        end else if (take_rw) begin
            pend_rw <= 1'b0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_MODE: reg_rdata = REG_W'({no_pre, divider});
            SEL_CMD:  reg_rdata = REG_W'(cmd_q);
            SEL_ADDR: reg_rdata = REG_W'({reg_ad, 3'b000, phy_ad});
            SEL_TXD:  reg_rdata = REG_W'(tx_data);
            SEL_RXD:  reg_rdata = REG_W'(rx_data);
            SEL_STAT: reg_rdata = REG_W'({invalid, busy, link_fail});
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_engine.sv
// Frame engine of the MDIO master.
// On each MDC falling strobe it starts a frame or drives the next bit;
// on each rising strobe of a read data phase it samples the line.
// A pending read/write wins over a scan; a new frame may start on the
// same falling edge that ends the previous one, so scans run back to back.
// Assumes the strobes come from mdio_clkgen and are mutually exclusive.
module mdio_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    input  logic        no_pre,
    input  logic        pend_rw,
    input  logic        pend_wr,
    input  logic        scan_en,
    input  logic        scan_arm,
    input  logic [4:0]  phy_ad,
    input  logic [4:0]  reg_ad,
    input  logic [15:0] tx_data,
    output logic        take_rw,
    output logic        active,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] rx_data,
    output logic        link_fail,
    output logic        invalid
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(PRE_BITS + FRAME_BITS - 1);
    localparam logic [POS_W-1:0] FRAME_POS = POS_W'(PRE_BITS);

    op_e                  op_q;
    logic [POS_W-1:0]     pos;
    logic [HDR_BITS-1:0]  hdr_q;
    logic [DATA_BITS-1:0] wd_q;
    logic [DATA_BITS-1:0] rsh;

    logic                 at_last;
    logic                 free;
    logic                 start_rw;
    logic                 start_scan;
    logic                 starting;
    op_e                  op_n;
    logic [HDR_BITS-1:0]  hdr_n;
    logic [POS_W-1:0]     pos_start;
    logic [1:0]           first_bit;
    logic [1:0]           step_bit;

    // Returns {oe, out} for frame position p (0..63, preamble first).
    function automatic logic [1:0] frame_bit(
        input logic [POS_W-1:0]     p,
        input logic [HDR_BITS-1:0]  hdr,
        input logic                 rd,
        input logic [DATA_BITS-1:0] wd
    );
        logic [4:0] f;
        f = p[4:0];
        if (!p[5])               return 2'b11;
        else if (f < 5'd14)      return {1'b1, hdr[4'(5'd13 - f)]};
        else if (rd)             return 2'b01;
        else if (f == 5'd14)     return 2'b11;
        else if (f == 5'd15)     return 2'b10;
        else                     return {1'b1, wd[4'(5'd31 - f)]};
    endfunction

    // Start decisions and the bit to drive next.
    always_comb begin
        at_last    = active && (pos == LAST_POS);
        free       = !active || at_last;
        start_rw   = fall_stb && free && pend_rw;
        start_scan = fall_stb && free && !pend_rw && scan_en;
        starting   = start_rw || start_scan;
        op_n       = start_rw ? (pend_wr ? OP_WRITE : OP_READ) : OP_SCAN;
        hdr_n      = {2'b01, (op_n == OP_WRITE) ? 2'b01 : 2'b10, phy_ad, reg_ad};
        pos_start  = no_pre ? FRAME_POS : '0;
        first_bit  = frame_bit(pos_start, hdr_n, op_n != OP_WRITE, tx_data);
        step_bit   = frame_bit(pos + POS_W'(1), hdr_q, op_q != OP_WRITE, wd_q);
    end

    assign take_rw = start_rw;

    // Frame sequencing and line drive on falling MDC strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            op_q     <= OP_NONE;
            pos      <= '0;
            hdr_q    <= '0;
            wd_q     <= '0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
        end else if (fall_stb) begin
            if (starting) begin
                active              <= 1'b1;
                op_q                <= op_n;
                pos                 <= pos_start;
                hdr_q               <= hdr_n;
                wd_q                <= tx_data;
                {mdio_oe, mdio_out} <= first_bit;
            end else if (at_last) begin
                active  <= 1'b0;
                op_q    <= OP_NONE;
                mdio_oe <= 1'b0;
            end else if (active) begin
                pos                 <= pos + POS_W'(1);
                {mdio_oe, mdio_out} <= step_bit;
            end
        end
    end

    // Read data capture on rising MDC strobes during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsh <= '0;
        end else if (rise_stb && active && (op_q != OP_WRITE) && pos[5] && pos[4]) begin
            rsh <= {rsh[DATA_BITS-2:0], mdio_in};
        end
    end

    // Result registers and scan status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            link_fail <= 1'b0;
            invalid   <= 1'b0;
        end else begin
            if (scan_arm) invalid <= 1'b1;
            if (fall_stb && at_last && (op_q != OP_WRITE)) begin
                rx_data <= rsh;
                if (op_q == OP_SCAN) begin
                    link_fail <= ~rsh[2];
                    invalid   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO management master, top level.
// Connects the register file, the MDC generator and the frame engine.
// Assumes the pad combines mdio_out/mdio_oe into an open line with a
// pull-up and returns the line level on mdio_in.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int             DW        = DIV_W,
    parameter logic [DW-1:0]  RESET_DIV = DW'(100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic             mdio_in
);
    logic [DW-1:0] divider;
    logic          no_pre;
    logic          scan_en;
    logic          pend_rw;
    logic          pend_wr;
    logic          scan_arm;
    logic [4:0]    phy_ad;
    logic [4:0]    reg_ad;
    logic [15:0]   tx_data;
    logic          busy;
    logic          take_rw;
    logic          active;
    logic [15:0]   rx_data;
    logic          link_fail;
    logic          invalid;
    logic          rise_stb;
    logic          fall_stb;

    mdio_regs #(.DW(DW), .RESET_DIV(RESET_DIV)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .take_rw   (take_rw),
        .active    (active),
        .rx_data   (rx_data),
        .link_fail (link_fail),
        .invalid   (invalid),
        .divider   (divider),
        .no_pre    (no_pre),
        .scan_en   (scan_en),
        .pend_rw   (pend_rw),
        .pend_wr   (pend_wr),
        .scan_arm  (scan_arm),
        .phy_ad    (phy_ad),
        .reg_ad    (reg_ad),
        .tx_data   (tx_data),
        .busy      (busy)
    );

    mdio_clkgen #(.DW(DW)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .divider  (divider),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_in   (mdio_in),
        .no_pre    (no_pre),
        .pend_rw   (pend_rw),
        .pend_wr   (pend_wr),
        .scan_en   (scan_en),
        .scan_arm  (scan_arm),
        .phy_ad    (phy_ad),
        .reg_ad    (reg_ad),
        .tx_data   (tx_data),
        .take_rw   (take_rw),
        .active    (active),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rx_data   (rx_data),
        .link_fail (link_fail),
        .invalid   (invalid)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Assertion checker for mdio_master, attached with bind below.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             reg_wr,
    input logic [2:0]       reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             busy,
    input logic             invalid,
    input logic             rise_stb,
    input logic             fall_stb
);
    // Reset leaves the line released and no status raised.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mdio_oe && !busy && !invalid));

    // The clock generator never flags both edges at once.
    assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));

    // The driven value only moves with a falling MDC edge.
    assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_out) |-> $fell(mdc));

    // The line enable (drive and release) only moves with a falling MDC edge.
    assert_oe_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $fell(mdc));

    // A read or write command raises busy on the next clock.
    assert_busy_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == SEL_CMD) && (reg_wdata[1] || reg_wdata[2])) |=> busy);

    // Invalid drops only at a frame end, which is a falling MDC edge.
    assert_invalid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(invalid) |-> $fell(mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .invalid   (invalid),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
);

// File: tb/sim_mdio_master.sv
// Scoreboard bench: driver tasks queue the frames they expect, and a PHY
// model decodes each frame on the wire and compares it with the queue.
module sim_mdio_master;
    localparam logic [4:0] PHY_ADDR = 5'd1;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        line;
    logic        phy_oe = 1'b0;
    logic        phy_out = 1'b1;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          oe_cnt = 0;
    int          frame_cnt = 0;
    bit          scan_tb = 1'b0;
    bit          finished = 1'b0;
    logic [4:0]  scan_reg = 5'd1;
    logic [15:0] phy_mem [32];
    sb_item_t    exp_q [$];

    always #5ns clk = ~clk;

    assign line = mdio_oe ? mdio_out : (phy_oe ? phy_out : 1'b1);

    mdio_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (line)
    );

    always @(posedge clk) cyc++;
    always @(posedge mdc) if (mdio_oe) oe_cnt++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd_reg(3'd5, s);
            if (!s[1]) break;
        end
    endtask

    task automatic mdc_period(output int per);
        int t0;
        @(posedge mdc); @(posedge mdc);
        t0 = cyc;
        @(posedge mdc);
        per = cyc - t0;
    endtask

    // Driver: queue the expected frame, launch it, wait, clear command.
    task automatic phy_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                             input int exp_oe);
        sb_item_t it;
        logic [31:0] s;
        int c0;
        it = '{wr: 1'b1, phy: phy, rg: rg, data: d};
        exp_q.push_back(it);
        wr_reg(3'd2, {19'd0, rg, 3'd0, phy});
        wr_reg(3'd3, {16'd0, d});
        c0 = oe_cnt;
        wr_reg(3'd1, 32'd4);
        rd_reg(3'd5, s);
        check(s[1] == 1'b1, "R6 busy after write command", s, 32'h2);
        wait_idle();
        check(oe_cnt - c0 == exp_oe, "R3 write driven cycles", oe_cnt - c0, exp_oe);
        wr_reg(3'd1, 32'd0);
    endtask

    task automatic phy_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp_d,
                            input int exp_oe, input string tag);
        sb_item_t it;
        logic [31:0] s;
        int c0;
        it = '{wr: 1'b0, phy: phy, rg: rg, data: 16'd0};
        exp_q.push_back(it);
        wr_reg(3'd2, {19'd0, rg, 3'd0, phy});
        c0 = oe_cnt;
        wr_reg(3'd1, 32'd2);
        rd_reg(3'd5, s);
        check(s[1] == 1'b1, "R6 busy after read command", s, 32'h2);
        wait_idle();
        check(oe_cnt - c0 == exp_oe, "R5 read releases at turnaround (driven cycles)", oe_cnt - c0, exp_oe);
        rd_reg(3'd4, s);
        check(s == {16'd0, exp_d}, tag, s, {16'd0, exp_d});
        wr_reg(3'd1, 32'd0);
    endtask

    // PHY model and scoreboard monitor.
    initial begin
        logic        s1;
        logic [11:0] hb;
        logic [15:0] d;
        sb_item_t    it;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0;
        forever begin
            @(posedge mdc);
            if (mdio_oe && line == 1'b0) begin
                @(posedge mdc); s1 = line;
                for (int i = 0; i < 12; i++) begin
                    @(posedge mdc); hb = {hb[10:0], line};
                end
                frame_cnt++;
                if (s1 && hb[11:10] == 2'b10) begin
                    @(negedge mdc);
                    @(negedge mdc);
                    if (hb[9:5] == PHY_ADDR) begin phy_oe = 1'b1; phy_out = 1'b0; end
                    d = phy_mem[hb[4:0]];
                    for (int i = 0; i < 16; i++) begin
                        @(negedge mdc); phy_out = d[15-i];
                    end
                    @(negedge mdc); phy_oe = 1'b0; phy_out = 1'b1;
                    if (scan_tb) begin
                        check(hb[4:0] == scan_reg, "R7 scan frame register", hb[4:0], scan_reg);
                    end else if (exp_q.size() == 0) begin
                        check(1'b0, "R5 unexpected read frame", hb, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(!it.wr && hb[9:5] == it.phy && hb[4:0] == it.rg,
                              "R5 read frame opcode/addresses", hb, {2'b10, it.phy, it.rg});
                    end
                end else if (s1 && hb[11:10] == 2'b01) begin
                    @(posedge mdc); s1 = line;
                    @(posedge mdc); s1 = s1 & ~line;
                    for (int i = 0; i < 16; i++) begin
                        @(posedge mdc); d = {d[14:0], line};
                    end
                    if (hb[9:5] == PHY_ADDR) phy_mem[hb[4:0]] = d;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected write frame", hb, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(it.wr && s1 && hb[9:5] == it.phy && hb[4:0] == it.rg && d == it.data,
                              "R4 write frame fields", {hb, d}, {2'b01, it.phy, it.rg, it.data});
                    end
                end else begin
                    check(1'b0, "R4 bad start/opcode", {s1, hb}, 0);
                end
            end
        end
    end

    // Main sequence.
    initial begin
        logic [31:0] v;
        int per;
        int fc;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd5, v); check(v == 32'd0, "R1 status after reset", v, 0);
        rd_reg(3'd4, v); check(v == 32'd0, "R1 rx data after reset", v, 0);
        rd_reg(3'd0, v); check(v == 32'd100, "R1 mode after reset", v, 100);
        check(mdio_oe == 1'b0, "R1 line released after reset", mdio_oe, 0);

        // R9 register read-back masks
        wr_reg(3'd2, 32'hFFFF_FFFF); rd_reg(3'd2, v); check(v == 32'h1F1F, "R9 address mask", v, 32'h1F1F);
        wr_reg(3'd3, 32'hABCD_1234); rd_reg(3'd3, v); check(v == 32'h1234, "R9 tx data mask", v, 32'h1234);
        wr_reg(3'd0, 32'hFFFF_FFFF); rd_reg(3'd0, v); check(v == 32'h1FF, "R9 mode mask", v, 32'h1FF);
        wr_reg(3'd2, 32'd0);

        // R2 divider 8, preamble on
        wr_reg(3'd0, 32'd8);
        mdc_period(per); check(per == 8, "R2 period div 8", per, 8);
        phy_write(PHY_ADDR, 5'd5, 16'hA5C3, 64);
        phy_read(PHY_ADDR, 5'd5, 16'hA5C3, 46, "R5 read data with preamble");

        // R2 odd divider, R3 preamble suppressed
        wr_reg(3'd0, 32'h105);
        mdc_period(per); check(per == 4, "R2 period div 5 (bit 0 ignored)", per, 4);
        phy_write(PHY_ADDR, 5'd9, 16'h1234, 32);
        phy_read(PHY_ADDR, 5'd9, 16'h1234, 14, "R3 read data without preamble");
        phy_read(5'd3, 5'd5, 16'hFFFF, 14, "R5 absent PHY reads pull-up");

        // R2 minimum divider
        wr_reg(3'd0, 32'd1);
        mdc_period(per); check(per == 2, "R2 period div 1", per, 2);
        phy_write(PHY_ADDR, 5'd0, 16'h8001, 64);
        phy_read(PHY_ADDR, 5'd0, 16'h8001, 46, "R5 read data fast clock");

        // R10 writing zero starts nothing
        fc = frame_cnt;
        wr_reg(3'd1, 32'd0);
        rd_reg(3'd5, v); check(v[1] == 1'b0, "R10 busy stays low", v, 0);
        repeat (400) @(posedge clk);
        check(frame_cnt == fc, "R10 no frame started", frame_cnt, fc);

        // R7/R8 scan
        wr_reg(3'd0, 32'd4);
        phy_mem[1] = 16'h786D;
        scan_reg = 5'd1;
        scan_tb = 1'b1;
        wr_reg(3'd2, {19'd0, 5'd1, 3'd0, PHY_ADDR});
        wr_reg(3'd1, 32'd1);
        rd_reg(3'd5, v); check(v[2:1] == 2'b11, "R8 invalid and busy set on scan start", v, 32'h6);
        for (int i = 0; i < 20000; i++) begin
            rd_reg(3'd5, v);
            if (!v[2]) break;
        end
        check(v[2:0] == 3'b010, "R8 invalid cleared, link ok, still busy R6", v, 32'h2);
        rd_reg(3'd4, v); check(v == 32'h786D, "R7 first scan result", v, 32'h786D);
        phy_mem[1] = 16'h7869;
        fc = frame_cnt;
        while (frame_cnt < fc + 3) @(posedge clk);
        rd_reg(3'd5, v); check(v[0] == 1'b1, "R7 link fail follows bit 2", v, 1);
        rd_reg(3'd4, v); check(v == 32'h7869, "R7 later scan result", v, 32'h7869);
        wr_reg(3'd1, 32'd0);
        wait_idle();
        scan_tb = 1'b0;
        rd_reg(3'd5, v); check(v[1] == 1'b0, "R6 busy clears after scan stop", v, 0);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule